// File: doc/BRIEF.md
# Stream Prefetch Engine with Speculative Step Recovery

This block holds one memory stream that software configures once, before a loop starts. A stream is either sequential or indirect. A sequential stream walks addresses as a base plus a scaled stride. An indirect stream first reads an index from a sequential index walk, then adds that index, shifted by a scale, to a second base. Once configured, the engine fetches elements on its own, whatever the consumer's loop branches do. Fetches go through a request/response memory port whose answers come back in issue order. Each fetched element lands in a slot of a small ring, and that slot is chosen by the element number modulo the ring depth.

The consumer sees the current element through a read port that behaves like a register. A step command moves to the next element. A squash command undoes a step that was issued down a mispredicted path. A commit command frees the oldest element that has been stepped past, and only then may the engine reuse its slot. Recovery works at two levels. A squash only moves the iteration index back, so the ring keeps its data and nothing is fetched again. A revert restores the iteration index and the oldest live element from a saved checkpoint, clears the ring, and refetches from that point. A memory fault is stored with its element and shows only when that element is read. An end command releases the stream. Responses still in flight after an end, a revert or a new configuration are counted and discarded.

The controller has five states. `ST_IDLE` means no stream is held. `ST_AFF_RUN` issues sequential element requests. `ST_IND_IDX` issues the index request of the next indirect element. `ST_IND_WAIT` waits for that index. `ST_IND_DATA` issues the data request built from the index. The transitions are:
- configure: any state to `ST_AFF_RUN` or `ST_IND_IDX`.
- end: any state to `ST_IDLE`.
- revert: any active state to the first issuing state of its mode.
- index issued: `ST_IND_IDX` to `ST_IND_WAIT`.
- index returned: `ST_IND_WAIT` to `ST_IND_DATA`, or back to `ST_IND_IDX` if the index faulted.
- data issued: `ST_IND_DATA` to `ST_IND_IDX`.

Top module: `strm_prefetch_engine`

## Requirements
- R1: After reset, `mem_req_valid` and `rd_valid` are low.
- R2: Requests start on the cycle after configuration, with no read needed. Sequential element i is fetched from `cfg_base + ((i*cfg_stride) << cfg_esize)` (16-bit wrap), in increasing element order.
- R3: Issue stops once `cfg_len` elements have been issued. It also stalls while DEPTH issued elements are not yet committed.
- R4: Indirect element i first reads its index from `cfg_idx_base + ((i*cfg_stride) << cfg_esize)`. It then reads its data from `cfg_base + (index << cfg_scale)`. That makes two requests per element.
- R5: With `rd_req` high, `rd_valid` rises only when the current element's data has arrived, and `rd_data` carries that element. Right after configuration `rd_valid` is low.
- R6: `cmd_step` moves to the next element, up to `cfg_len`. `cmd_commit` frees the oldest stepped-past element's slot. Once every element is consumed, `rd_valid` stays low.
- R7: `cmd_squash` moves the current element back by one, but never below the oldest uncommitted element. The ring data is kept and no request is reissued.
- R8: `cmd_ckpt` saves the current and oldest-live element numbers. `cmd_revert` restores both, clears the ring, and refetches from the oldest live element, so `rd_valid` is low in the cycle after the revert.
- R9: A fault response is stored with its element. `rd_fault` is high only while that element is being read, together with `rd_valid`. For an indirect element, a fault on its index read also marks it faulty.
- R10: `cmd_end` stops all requests and drops `rd_valid`. Responses still outstanding are discarded, so a later configuration delivers correct data.
- R11: `mem_req_tag` equals the element number modulo DEPTH (DEPTH a power of two). Data responses return that tag in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Load a new stream configuration |
| cfg_indirect | input | 1 | 1 selects an indirect stream |
| cfg_base | input | AW | Data base address |
| cfg_idx_base | input | AW | Index base address (indirect only) |
| cfg_stride | input | AW | Stride in elements |
| cfg_esize | input | 2 | Element size as log2 of bytes |
| cfg_scale | input | SCALE_W | Left shift applied to an index |
| cfg_len | input | LEN_W | Number of elements |
| cmd_step | input | 1 | Advance the current element |
| cmd_commit | input | 1 | Free the oldest stepped-past element |
| cmd_squash | input | 1 | Undo one speculative step |
| cmd_ckpt | input | 1 | Save a checkpoint |
| cmd_revert | input | 1 | Restore the checkpoint |
| cmd_end | input | 1 | Release the stream |
| rd_req | input | 1 | Consumer reads the current element |
| rd_valid | output | 1 | Current element is present |
| rd_data | output | DW | Current element data |
| rd_fault | output | 1 | Current element carries a fault |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Request address |
| mem_req_tag | output | TAG_W | Request slot tag |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_tag | input | TAG_W | Response slot tag |
| mem_rsp_data | input | DW | Response data |
| mem_rsp_fault | input | 1 | Response carries a fault |

## Verification
The hardest case to reach is a squash or revert taken while the ring is full and requests are still in flight. Stale responses then arrive after the engine has moved to new element numbers. The stimulus builds this up on purpose: it configures a stream longer than the ring and waits until issue stalls. It then steps forward without committing, and squashes back repeatedly, including once at the floor. A revert, and separately an end, are issued while the memory model is still holding responses, and the following reads must show correctly refetched data. The memory model accepts and answers on pseudo-random cycles, so arrival order against consumer commands varies across the configuration sweeps.

// File: rtl/strm_pkg.sv
package strm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AFF_RUN,
        ST_IND_IDX,
        ST_IND_WAIT,
        ST_IND_DATA
    } strm_state_e;

endpackage

// File: rtl/strm_addr_gen.sv
module strm_addr_gen #(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int CW      = 8,
    parameter int SCALE_W = 2
) (
    input  logic [AW-1:0]      walk_base,
    input  logic [AW-1:0]      stride,
    input  logic [1:0]         esize,
    input  logic [CW-1:0]      elem,
    input  logic [AW-1:0]      data_base,
    input  logic [DW-1:0]      index_val,
    input  logic [SCALE_W-1:0] scale,
    output logic [AW-1:0]      walk_addr,
    output logic [AW-1:0]      gather_addr
);

    logic [AW-1:0] step_off;

    always_comb begin
        step_off    = stride * AW'(elem);
        walk_addr   = walk_base + (step_off << esize);
        gather_addr = data_base + (AW'(index_val) << scale);
    end

endmodule

// File: rtl/strm_slots.sv
module strm_slots #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_fault,
    input  logic          inv_en,
    input  logic [IW-1:0] inv_idx,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_present,
    output logic [DW-1:0] rd_data,
    output logic          rd_fault,
    input  logic [IW-1:0] old_idx,
    output logic          old_present
);

    logic [DEPTH-1:0] present_q;
    logic [DEPTH-1:0] fault_q;
    logic [DW-1:0]    data_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                present_q[g] <= 1'b0;
                fault_q[g]   <= 1'b0;
                data_q[g]    <= '0;
            end else if (clr_all) begin
                present_q[g] <= 1'b0;
                fault_q[g]   <= 1'b0;
            end else if (wr_en && (wr_idx == IW'(g))) begin
                present_q[g] <= 1'b1;
                fault_q[g]   <= wr_fault;
                data_q[g]    <= wr_data;
            end else if (inv_en && (inv_idx == IW'(g))) begin
                present_q[g] <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_present  = present_q[rd_idx];
        rd_data     = data_q[rd_idx];
        rd_fault    = fault_q[rd_idx];
        old_present = present_q[old_idx];
    end

    // R11
    slot_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |-> !present_q[wr_idx]);

    // R6
    free_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !clr_all) |-> present_q[inv_idx]);

endmodule

// File: rtl/strm_prefetch_engine.sv
module strm_prefetch_engine
    import strm_pkg::*;
#(
    parameter int AW      = 16,
    parameter int DW      = 16,
    parameter int DEPTH   = 8,
    parameter int LEN_W   = 8,
    parameter int SCALE_W = 2,
    localparam int TAG_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic               cfg_indirect,
    input  logic [AW-1:0]      cfg_base,
    input  logic [AW-1:0]      cfg_idx_base,
    input  logic [AW-1:0]      cfg_stride,
    input  logic [1:0]         cfg_esize,
    input  logic [SCALE_W-1:0] cfg_scale,
    input  logic [LEN_W-1:0]   cfg_len,
    input  logic               cmd_step,
    input  logic               cmd_commit,
    input  logic               cmd_squash,
    input  logic               cmd_ckpt,
    input  logic               cmd_revert,
    input  logic               cmd_end,
    input  logic               rd_req,
    output logic               rd_valid,
    output logic [DW-1:0]      rd_data,
    output logic               rd_fault,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [AW-1:0]      mem_req_addr,
    output logic [TAG_W-1:0]   mem_req_tag,
    input  logic               mem_rsp_valid,
    input  logic [TAG_W-1:0]   mem_rsp_tag,
    input  logic [DW-1:0]      mem_rsp_data,
    input  logic               mem_rsp_fault
);

    localparam int CW = LEN_W;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    strm_state_e state_q, state_d;

    // configuration held for the life of the stream
    logic               ind_q;
    logic [AW-1:0]      base_q, ibase_q, stride_q;
    logic [1:0]         esize_q;
    logic [SCALE_W-1:0] scale_q;
    logic [CW-1:0]      len_q;

    // element counters: committed <= current, committed <= issued
    logic [CW-1:0] head_q, ret_q, iss_q;
    logic [CW-1:0] ck_head_q, ck_ret_q;
    logic [CW-1:0] outs_q, drop_q;
    logic [DW-1:0] idx_q;

    logic          active, room, flush, req_fire;
    logic          rsp_keep, idx_rsp, dat_rsp;
    logic          iss_inc, step_ok, squash_ok, commit_ok;
    logic [CW-1:0] occ, outs_n;
    logic [AW-1:0] walk_addr, gather_addr;
    logic          hd_present, hd_fault, old_present;
    logic [DW-1:0] hd_data;
    logic          wr_en;
    logic [TAG_W-1:0] wr_idx;

    always_comb begin
        active    = (state_q != ST_IDLE);
        occ       = iss_q - ret_q;
        room      = (iss_q < len_q) && (occ < DEPTH_C);
        flush     = cfg_valid || cmd_end || (cmd_revert && active);
        req_fire  = mem_req_valid && mem_req_ready;
        rsp_keep  = mem_rsp_valid && (drop_q == '0);
        idx_rsp   = rsp_keep && (state_q == ST_IND_WAIT) && (outs_q == CW'(1));
        dat_rsp   = rsp_keep && !idx_rsp;
        iss_inc   = (req_fire && ((state_q == ST_AFF_RUN) || (state_q == ST_IND_DATA)))
                 || (idx_rsp && mem_rsp_fault);
        squash_ok = active && cmd_squash && (head_q > ret_q);
        step_ok   = active && cmd_step && !cmd_squash && (head_q < len_q);
        commit_ok = active && cmd_commit && !cmd_squash && !cmd_step
                 && (ret_q < head_q) && old_present;
        outs_n    = outs_q + CW'(req_fire) - CW'(mem_rsp_valid);
        wr_en     = dat_rsp || (idx_rsp && mem_rsp_fault);
        wr_idx    = dat_rsp ? mem_rsp_tag : iss_q[TAG_W-1:0];
    end

    strm_addr_gen #(
        .AW(AW), .DW(DW), .CW(CW), .SCALE_W(SCALE_W)
    ) u_addr (
        .walk_base   (ind_q ? ibase_q : base_q),
        .stride      (stride_q),
        .esize       (esize_q),
        .elem        (iss_q),
        .data_base   (base_q),
        .index_val   (idx_q),
        .scale       (scale_q),
        .walk_addr   (walk_addr),
        .gather_addr (gather_addr)
    );

    strm_slots #(
        .DEPTH(DEPTH), .DW(DW)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_all     (flush),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .wr_data     (dat_rsp ? mem_rsp_data : '0),
        .wr_fault    (mem_rsp_fault),
        .inv_en      (commit_ok),
        .inv_idx     (ret_q[TAG_W-1:0]),
        .rd_idx      (head_q[TAG_W-1:0]),
        .rd_present  (hd_present),
        .rd_data     (hd_data),
        .rd_fault    (hd_fault),
        .old_idx     (ret_q[TAG_W-1:0]),
        .old_present (old_present)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (cfg_valid) begin
            state_d = cfg_indirect ? ST_IND_IDX : ST_AFF_RUN;
        end else if (cmd_end) begin
            state_d = ST_IDLE;
        end else if (cmd_revert && active) begin
            state_d = ind_q ? ST_IND_IDX : ST_AFF_RUN;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_AFF_RUN:  state_d = ST_AFF_RUN;
                ST_IND_IDX:  if (req_fire) state_d = ST_IND_WAIT;
                ST_IND_WAIT: if (idx_rsp) state_d = mem_rsp_fault ? ST_IND_IDX : ST_IND_DATA;
                ST_IND_DATA: if (req_fire) state_d = ST_IND_IDX;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_addr  = walk_addr;
        mem_req_tag   = iss_q[TAG_W-1:0];
        unique case (state_q)
            ST_IDLE:     mem_req_valid = 1'b0;
            ST_AFF_RUN:  mem_req_valid = room;
            ST_IND_IDX:  mem_req_valid = room;
            ST_IND_WAIT: mem_req_valid = 1'b0;
            ST_IND_DATA: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = gather_addr;
            end
            default:     mem_req_valid = 1'b0;
        endcase
        rd_valid = active && rd_req && (head_q < iss_q) && hd_present;
        rd_data  = hd_data;
        rd_fault = rd_valid && hd_fault;
    end

    // counters and configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ind_q     <= 1'b0;
            base_q    <= '0;
            ibase_q   <= '0;
            stride_q  <= '0;
            esize_q   <= '0;
            scale_q   <= '0;
            len_q     <= '0;
            head_q    <= '0;
            ret_q     <= '0;
            iss_q     <= '0;
            ck_head_q <= '0;
            ck_ret_q  <= '0;
            outs_q    <= '0;
            drop_q    <= '0;
            idx_q     <= '0;
        end else begin
            outs_q <= outs_n;
            if (flush)                             drop_q <= outs_n;
            else if (mem_rsp_valid && drop_q != '0) drop_q <= drop_q - CW'(1);
            if (idx_rsp && !mem_rsp_fault) idx_q <= mem_rsp_data;

            if (cfg_valid) begin
                ind_q     <= cfg_indirect;
                base_q    <= cfg_base;
                ibase_q   <= cfg_idx_base;
                stride_q  <= cfg_stride;
                esize_q   <= cfg_esize;
                scale_q   <= cfg_scale;
                len_q     <= cfg_len;
                head_q    <= '0;
                ret_q     <= '0;
                iss_q     <= '0;
                ck_head_q <= '0;
                ck_ret_q  <= '0;
            end else if (cmd_end) begin
                head_q <= '0;
                ret_q  <= '0;
                iss_q  <= '0;
            end else if (cmd_revert && active) begin
                head_q <= ck_head_q;
                ret_q  <= ck_ret_q;
                iss_q  <= ck_ret_q;
            end else begin
                if (iss_inc)        iss_q  <= iss_q + CW'(1);
                if (squash_ok)      head_q <= head_q - CW'(1);
                else if (step_ok)   head_q <= head_q + CW'(1);
                if (commit_ok)      ret_q  <= ret_q + CW'(1);
                if (cmd_ckpt && active) begin
                    ck_head_q <= head_q;
                    ck_ret_q  <= ret_q;
                end
            end
        end
    end

    // R3
    occ_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_C);

    // R3
    len_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (iss_q < len_q));

    // R6
    head_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ret_q <= head_q);

    // R9
    fault_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fault |-> (rd_req && rd_valid));

    // R7
    rollback_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (squash_ok && !flush) |=> (head_q == $past(head_q) - CW'(1)) && (iss_q >= $past(iss_q)));

    // R10
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_end && !cfg_valid) |=> (!mem_req_valid && !rd_valid));

endmodule

// File: tb/tb_strm_prefetch_engine.sv
module tb_strm_prefetch_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 0, cfg_indirect = 0;
    logic [15:0] cfg_base = 0, cfg_idx_base = 0, cfg_stride = 0;
    logic [1:0]  cfg_esize = 0, cfg_scale = 0;
    logic [7:0]  cfg_len = 0;
    logic        cmd_step = 0, cmd_commit = 0, cmd_squash = 0, cmd_ckpt = 0, cmd_revert = 0, cmd_end = 0;
    logic        rd_req = 1'b1;
    logic        rd_valid, rd_fault;
    logic [15:0] rd_data;
    logic        mem_req_valid, mem_req_ready = 0;
    logic [15:0] mem_req_addr;
    logic [2:0]  mem_req_tag;
    logic        mem_rsp_valid = 0, mem_rsp_fault = 0;
    logic [2:0]  mem_rsp_tag = 0;
    logic [15:0] mem_rsp_data = 0;

    always #4 clk = ~clk;

    strm_prefetch_engine dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_indirect(cfg_indirect), .cfg_base(cfg_base),
        .cfg_idx_base(cfg_idx_base), .cfg_stride(cfg_stride), .cfg_esize(cfg_esize),
        .cfg_scale(cfg_scale), .cfg_len(cfg_len),
        .cmd_step(cmd_step), .cmd_commit(cmd_commit), .cmd_squash(cmd_squash),
        .cmd_ckpt(cmd_ckpt), .cmd_revert(cmd_revert), .cmd_end(cmd_end),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rd_fault(rd_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_tag(mem_req_tag),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_fault(mem_rsp_fault)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // current stream as seen by the bench
    logic        g_ind;
    logic [15:0] g_base, g_ibase, g_stride;
    logic [1:0]  g_esize, g_scale;
    logic [15:0] fault_addr = 0;
    bit          fault_en = 0;
    bit          chk_addr = 0;
    int          req_cnt = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mem_fn(input logic [15:0] a);
        return a * 16'd7 + 16'h0123;
    endfunction

    function automatic logic [15:0] walk_addr(input int i);
        return g_ind ? g_ibase + ((g_stride * 16'(i)) << g_esize)
                     : g_base + ((g_stride * 16'(i)) << g_esize);
    endfunction

    function automatic logic [15:0] elem_addr(input int i);
        if (!g_ind) return walk_addr(i);
        return g_base + (mem_fn(walk_addr(i)) << g_scale);
    endfunction

    function automatic bit elem_fault(input int i);
        if (!fault_en) return 0;
        if (g_ind && walk_addr(i) == fault_addr) return 1;
        return elem_addr(i) == fault_addr;
    endfunction

    // memory model: random accept, in-order random-latency responses
    logic [15:0] qa [64];
    logic [2:0]  qt [64];
    int qh = 0, qtl = 0;
    logic [15:0] lfsr = 16'hACE1;

    always begin
        @(negedge clk);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        mem_req_ready = lfsr[1] | lfsr[4];
        if (qh != qtl && (lfsr[0] | lfsr[6])) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_tag   = qt[qh % 64];
            mem_rsp_data  = mem_fn(qa[qh % 64]);
            mem_rsp_fault = fault_en && (qa[qh % 64] == fault_addr);
            qh++;
        end else begin
            mem_rsp_valid = 1'b0;
        end
        #3;
        if (rst_n && mem_req_valid && mem_req_ready) begin
            qa[qtl % 64] = mem_req_addr;
            qt[qtl % 64] = mem_req_tag;
            qtl++;
            if (chk_addr) begin
                chk(mem_req_addr == walk_addr(req_cnt), "R2 request address", mem_req_addr, walk_addr(req_cnt));
                chk(mem_req_tag == 3'(req_cnt), "R11 request tag", mem_req_tag, 3'(req_cnt));
            end
            req_cnt++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic configure(input bit ind, input logic [15:0] base, input logic [15:0] ibase,
                             input logic [15:0] stride, input logic [1:0] esz, input logic [1:0] scl,
                             input int len);
        @(negedge clk);
        g_ind = ind; g_base = base; g_ibase = ibase; g_stride = stride; g_esize = esz; g_scale = scl;
        cfg_indirect = ind; cfg_base = base; cfg_idx_base = ibase; cfg_stride = stride;
        cfg_esize = esz; cfg_scale = scl; cfg_len = 8'(len); cfg_valid = 1'b1;
        @(negedge clk);
        cfg_valid = 1'b0;
        req_cnt = 0;
        chk_addr = !ind;
        chk(!rd_valid, "R5 no data right after configure", rd_valid, 0);
    endtask

    task automatic pulse_step();   @(negedge clk); cmd_step = 1;   @(negedge clk); cmd_step = 0;   endtask
    task automatic pulse_commit(); @(negedge clk); cmd_commit = 1; @(negedge clk); cmd_commit = 0; endtask
    task automatic pulse_squash(); @(negedge clk); cmd_squash = 1; @(negedge clk); cmd_squash = 0; endtask
    task automatic pulse_ckpt();   @(negedge clk); cmd_ckpt = 1;   @(negedge clk); cmd_ckpt = 0;   endtask
    task automatic pulse_revert(); @(negedge clk); cmd_revert = 1; @(negedge clk); cmd_revert = 0; endtask
    task automatic pulse_end();    @(negedge clk); cmd_end = 1;    @(negedge clk); cmd_end = 0;    endtask

    task automatic read_check(input int i, input string req);
        int w = 0;
        while (!rd_valid && w < 3000) begin
            @(negedge clk);
            w++;
        end
        chk(rd_valid, {req, " element arrives"}, rd_valid, 1);
        chk(rd_fault == elem_fault(i), {req, " fault flag"}, rd_fault, elem_fault(i));
        if (!elem_fault(i))
            chk(rd_data == mem_fn(elem_addr(i)), {req, " element data"}, rd_data, mem_fn(elem_addr(i)));
    endtask

    task automatic consume(input int from, input int to, input string req);
        for (int i = from; i < to; i++) begin
            read_check(i, req);
            pulse_step();
            pulse_commit();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        g_ind = 0; g_base = 0; g_ibase = 0; g_stride = 0; g_esize = 0; g_scale = 0;
        cyc(4);
        chk(!mem_req_valid, "R1 reset request", mem_req_valid, 0);
        chk(!rd_valid, "R1 reset read", rd_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(2);
        chk(!mem_req_valid && !rd_valid, "R1 idle after reset", {mem_req_valid, rd_valid}, 0);

        // sequential sweep (R2, R3, R5, R6, R11)
        for (int s = 0; s < 2; s++)
            for (int e = 0; e < 2; e++)
                for (int l = 0; l < 4; l++) begin
                    int len;
                    len = (l == 0) ? 0 : (l == 1) ? 1 : (l == 2) ? 5 : 12;
                    configure(0, 16'h1000 + 16'(s * 16'h40), 16'h0, (s == 0) ? 16'd1 : 16'd3, 2'(e), 2'd0, len);
                    consume(0, len, "R5 sequential");
                    cyc(10);
                    chk(req_cnt == len, "R3 issue count equals length", req_cnt, len);
                    chk(!rd_valid, "R6 nothing past the end", rd_valid, 0);
                    pulse_end();
                end

        // indirect sweep (R4)
        for (int sc = 0; sc < 3; sc++)
            for (int s = 1; s < 3; s++) begin
                configure(1, 16'h0040, 16'h0800, 16'(s), 2'd1, 2'(sc), 6);
                consume(0, 6, "R4 indirect");
                cyc(10);
                chk(req_cnt == 12, "R4 two requests per element", req_cnt, 12);
                pulse_end();
            end

        // stall and squash (R3, R7)
        configure(0, 16'h0300, 16'h0, 16'd1, 2'd0, 2'd0, 20);
        cyc(60);
        chk(req_cnt == 8, "R3 stall at ring depth", req_cnt, 8);
        read_check(0, "R6 first");
        pulse_step();
        read_check(1, "R6 after step");
        pulse_step();
        pulse_squash();
        read_check(1, "R7 squash back one");
        chk(req_cnt == 8, "R7 no refetch on squash", req_cnt, 8);
        pulse_squash();
        read_check(0, "R7 squash back two");
        pulse_squash();
        read_check(0, "R7 squash floor");
        cyc(10);
        chk(req_cnt == 8, "R7 ring still held", req_cnt, 8);
        consume(0, 20, "R6 drain after squash");
        cyc(10);
        chk(req_cnt == 20, "R3 full length issued", req_cnt, 20);
        pulse_end();

        // checkpoint and revert (R8)
        configure(0, 16'h0500, 16'h0, 16'd2, 2'd0, 2'd0, 10);
        chk_addr = 0;
        pulse_ckpt();
        consume(0, 3, "R8 before revert");
        pulse_revert();
        chk(!rd_valid, "R8 ring cleared on revert", rd_valid, 0);
        read_check(0, "R8 restored element");
        consume(0, 10, "R8 after revert");
        pulse_end();

        // deferred fault, sequential (R9)
        fault_en = 1;
        fault_addr = 16'h0206;
        configure(0, 16'h0200, 16'h0, 16'd1, 2'd1, 2'd0, 6);
        cyc(60);
        chk(rd_valid && !rd_fault, "R9 fault hidden until its element", {rd_valid, rd_fault}, 2'b10);
        consume(0, 6, "R9 sequential fault");
        pulse_end();

        // deferred fault on an index read (R9)
        fault_addr = 16'h0702;
        configure(1, 16'h0040, 16'h0700, 16'd1, 2'd0, 2'd0, 5);
        consume(0, 5, "R9 index fault");
        pulse_end();
        fault_en = 0;

        // end with traffic in flight, then reuse (R10)
        configure(0, 16'h0900, 16'h0, 16'd1, 2'd0, 2'd0, 30);
        cyc(3);
        pulse_end();
        chk(!mem_req_valid && !rd_valid, "R10 quiet after end", {mem_req_valid, rd_valid}, 0);
        begin
            int snap;
            cyc(1);
            snap = req_cnt;
            cyc(30);
            chk(req_cnt == snap, "R10 no requests after end", req_cnt, snap);
        end
        configure(0, 16'h0a00, 16'h0, 16'd1, 2'd0, 2'd0, 4);
        consume(0, 4, "R10 stale responses dropped");
        pulse_end();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule